// File: doc/BRIEF.md
# PHY Control Word Command Scheduler

This block sits between a command queue and the strobe inputs of a memory PHY's FIFOs. Each queue entry is a 32-bit control word. The block decodes the word into a write, read or non-data command. It then times two transfers separately:

- the pop of the address/command output FIFOs, after a control delay carried in the word;
- the data movement, after a data delay carried in the word. For a write this is a pop of the data output FIFO. For a read it is a push into the read-data input FIFO.

A two-bit sequence tag in each word must equal a local sync phase before the word is taken. The phase counter advances on external sync pulses, so several copies of the block can stay in step. Only one command is in flight at a time. Words with a bad command code or a non-zero reserved field are discarded, and a sticky error flag is raised.

Top module: `phyCmdScheduler`

## Requirements
- R1: Word layout: the command code is in bits [2:0], with 1 = write, 3 = read and 4 = non-data. The control delay is in [8:3], the reserved field in [17:16], the data delay in [23:18] and the sequence tag in [25:24].
- R2: For every well-formed command, `acPop` is high for exactly one cycle, `ctl+1` cycles after the handshake cycle. Here `ctl` is the control delay.
- R3: A write raises `dataPop` for exactly one cycle, `dat+1` cycles after the handshake, and never raises `rdPush`. Here `dat` is the data delay.
- R4: A read raises `rdPush` for exactly one cycle, `dat+RET_LAT+1` cycles after the handshake, and never raises `dataPop`.
- R5: A non-data command raises neither `dataPop` nor `rdPush`.
- R6: `syncPhase` is 0 after reset. It advances by one on every cycle in which `syncIn` is high and wraps modulo 4.
- R7: A well-formed word whose sequence tag differs from `syncPhase` is not accepted (`qReady` low) until the phase matches.
- R8: A word with a non-zero reserved field, or with a command code other than 1, 3 or 4, is consumed in one handshake whatever its tag. It produces no strobe. `errSticky` goes high in the next cycle and stays high until reset.
- R9: While a command is in flight `qReady` is low. `qReady` returns in the cycle after the later of that command's strobes.
- R10: Bits [15:9] and [31:26] have no effect on any strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Sync pulse that advances the phase |
| qValid | input | 1 | Queue head holds a word |
| qWord | input | 32 | Control word at the queue head |
| qReady | output | 1 | Word is taken at this edge when qValid is high |
| acPop | output | 1 | Pop strobe for address/command output FIFOs |
| dataPop | output | 1 | Pop strobe for the write-data output FIFO |
| rdPush | output | 1 | Push strobe for the read-data input FIFO |
| errSticky | output | 1 | A malformed word has been discarded |
| syncPhase | output | 2 | Current sync phase |

## Verification
The address/command pop and the data strobe run on independent timers, so they can fire in the same cycle. The bench provokes this with a write whose two delays are equal. It judges the result by the exact cycle index and the count of each strobe, both of which must match the formula for that strobe alone. The bench also runs a read whose control delay exceeds its data delay plus the return latency. This checks that the ready return follows whichever timer finishes last.

// File: rtl/schedPkg.sv
package schedPkg;
  localparam int WORD_W  = 32;
  localparam int CMD_W   = 3;
  localparam int OFF_W   = 6;
  localparam int SEQ_W   = 2;
  localparam int RSV_W   = 2;
  localparam int CMD_LSB = 0;
  localparam int CTL_LSB = 3;
  localparam int RSV_LSB = 16;
  localparam int DAT_LSB = 18;
  localparam int SEQ_LSB = 24;

  localparam logic [CMD_W-1:0] CODE_WR = 3'd1;
  localparam logic [CMD_W-1:0] CODE_RD = 3'd3;
  localparam logic [CMD_W-1:0] CODE_ND = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic acDec;
    logic dDec;
  } ctlStrobe_t;

  // decode result from datapath to control
  typedef struct packed {
    logic             good;
    logic             isWr;
    logic             isRd;
    logic [SEQ_W-1:0] seq;
  } decInfo_t;
endpackage

// File: rtl/schedDatapath.sv
module schedDatapath
  import schedPkg::*;
#(
  parameter int RET_LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] word,
  input  ctlStrobe_t        strobe,
  output decInfo_t          info,
  output logic              acZero,
  output logic              dZero
);
  localparam int CNT_W = $clog2((1 << OFF_W) + RET_LAT + 1);

  logic [CMD_W-1:0] cmdField;
  logic [OFF_W-1:0] ctlOff;
  logic [OFF_W-1:0] datOff;
  logic [RSV_W-1:0] rsvField;
  logic [CNT_W-1:0] acCnt;
  logic [CNT_W-1:0] dCnt;
  logic [CNT_W-1:0] dLoadVal;

  assign cmdField = word[CMD_LSB +: CMD_W];
  assign ctlOff   = word[CTL_LSB +: OFF_W];
  assign datOff   = word[DAT_LSB +: OFF_W];
  assign rsvField = word[RSV_LSB +: RSV_W];

  always_comb begin
    info.isWr = (cmdField == CODE_WR);
    info.isRd = (cmdField == CODE_RD);
    info.good = (info.isWr || info.isRd || cmdField == CODE_ND) && (rsvField == '0);
    info.seq  = word[SEQ_LSB +: SEQ_W];
  end

  // read data returns a fixed latency after the data slot
  assign dLoadVal = info.isRd ? CNT_W'(datOff) + CNT_W'(RET_LAT) : CNT_W'(datOff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acCnt <= '0;
      dCnt  <= '0;
    end else if (strobe.load) begin
      acCnt <= CNT_W'(ctlOff);
      dCnt  <= dLoadVal;
    end else begin
      if (strobe.acDec) acCnt <= acCnt - 1'b1;
      if (strobe.dDec)  dCnt  <= dCnt - 1'b1;
    end
  end

  assign acZero = (acCnt == '0);
  assign dZero  = (dCnt == '0);

  // R2: a load never coincides with a countdown step
  a_r2_load_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !(strobe.acDec || strobe.dDec));
endmodule

// File: rtl/schedControl.sv
module schedControl
  import schedPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic             qValid,
  input  decInfo_t         info,
  input  logic             acZero,
  input  logic             dZero,
  output logic             qReady,
  output ctlStrobe_t       strobe,
  output logic             acPop,
  output logic             dataPop,
  output logic             rdPush,
  output logic             errSticky,
  output logic [SEQ_W-1:0] syncPhase
);
  logic acPend;
  logic dPend;
  logic dIsRd;
  logic idle;
  logic accept;
  logic dFire;

  assign idle   = !acPend && !dPend;
  assign qReady = idle && (!info.good || info.seq == syncPhase);
  assign accept = qValid && qReady;

  assign acPop        = acPend && acZero;
  assign dFire        = dPend && dZero;
  assign dataPop      = dFire && !dIsRd;
  assign rdPush       = dFire && dIsRd;
  assign strobe.load  = accept && info.good;
  assign strobe.acDec = acPend && !acZero;
  assign strobe.dDec  = dPend && !dZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPhase <= '0;
      acPend    <= 1'b0;
      dPend     <= 1'b0;
      dIsRd     <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      if (syncIn) syncPhase <= syncPhase + 1'b1;
      if (strobe.load) begin
        acPend <= 1'b1;
        dPend  <= info.isWr || info.isRd;
        dIsRd  <= info.isRd;
      end else begin
        if (acPop) acPend <= 1'b0;
        if (dFire) dPend  <= 1'b0;
      end
      if (accept && !info.good) errSticky <= 1'b1;
    end
  end

  a_r2_ac_single: assert property (@(posedge clk) disable iff (!rstN)
    acPop |=> !acPop);
  a_r3_data_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(dataPop && rdPush));
  a_r5_nd_no_data: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !info.isWr && !info.isRd) |=> !dPend);
  a_r6_phase_step: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> syncPhase == $past(syncPhase) + 1'b1);
  a_r8_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (acPend || dPend) |-> !qReady);
endmodule

// File: rtl/phyCmdScheduler.sv
module phyCmdScheduler
  import schedPkg::*;
#(
  parameter int RET_LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic              qValid,
  input  logic [WORD_W-1:0] qWord,
  output logic              qReady,
  output logic              acPop,
  output logic              dataPop,
  output logic              rdPush,
  output logic              errSticky,
  output logic [SEQ_W-1:0]  syncPhase
);
  ctlStrobe_t strobe;
  decInfo_t   info;
  logic       acZero;
  logic       dZero;

  schedDatapath #(.RET_LAT(RET_LAT)) uDp (
    .clk(clk), .rstN(rstN), .word(qWord), .strobe(strobe),
    .info(info), .acZero(acZero), .dZero(dZero)
  );

  schedControl uCtl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .qValid(qValid),
    .info(info), .acZero(acZero), .dZero(dZero), .qReady(qReady),
    .strobe(strobe), .acPop(acPop), .dataPop(dataPop), .rdPush(rdPush),
    .errSticky(errSticky), .syncPhase(syncPhase)
  );

  // R7: a taken well-formed word always carries the current phase
  a_r7_phase_match: assert property (@(posedge clk) disable iff (!rstN)
    (qValid && qReady && info.good) |-> info.seq == syncPhase);
endmodule

// File: tb/tb_phyCmdScheduler.sv
module tb_phyCmdScheduler;
  localparam int LAT = 4;
  logic clk = 0, rstN = 0, syncIn = 0, qValid = 0;
  logic [31:0] qWord = '0;
  logic qReady, acPop, dataPop, rdPush, errSticky;
  logic [1:0] syncPhase;
  int total = 0, bad = 0, cyc = 0;
  int acN, dpN, rpN, acAt, dpAt, rpAt, readyAt;
  logic track = 0;
  logic done = 0;

  phyCmdScheduler #(.RET_LAT(LAT)) dut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .qValid(qValid), .qWord(qWord),
    .qReady(qReady), .acPop(acPop), .dataPop(dataPop), .rdPush(rdPush),
    .errSticky(errSticky), .syncPhase(syncPhase)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #1;
    if (acPop)   begin acN++; acAt = cyc; end
    if (dataPop) begin dpN++; dpAt = cyc; end
    if (rdPush)  begin rpN++; rpAt = cyc; end
    if (track && qReady && readyAt < 0) readyAt = cyc;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] cmd, input logic [5:0] ctl,
      input logic [5:0] dat, input logic [1:0] seq, input logic [1:0] rsv);
    logic [31:0] w = '0;
    w[2:0] = cmd; w[8:3] = ctl; w[17:16] = rsv; w[23:18] = dat; w[25:24] = seq;
    return w;
  endfunction

  task automatic clearMon();
    acN = 0; dpN = 0; rpN = 0; acAt = -1; dpAt = -1; rpAt = -1; readyAt = -1;
  endtask

  task automatic syncPulse(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); syncIn = 1; end
    @(negedge clk); syncIn = 0;
  endtask

  // present one well-formed word and check every strobe time (R1..R5, R9, R10)
  task automatic runCmd(input string tag, input logic [2:0] cmd, input int ctl, input int dat,
      input logic [1:0] seq, input logic [31:0] junk);
    int acc, expAc, expD, last;
    clearMon();
    @(negedge clk); qWord = mk(cmd, 6'(ctl), 6'(dat), seq, 2'b00) | junk; qValid = 1;
    #1;
    while (!qReady) begin @(negedge clk); #1; end
    acc = cyc;
    @(negedge clk); qValid = 0; qWord = '0; track = 1;
    repeat (90) @(negedge clk);
    track = 0;
    expAc = acc + ctl + 1;
    chk({tag, " R2"}, "acPop count", acN, 1);
    chk({tag, " R2"}, "acPop cycle", acAt, expAc);
    last = expAc;
    if (cmd == 3'd1) begin
      expD = acc + dat + 1;
      chk({tag, " R3"}, "dataPop count", dpN, 1);
      chk({tag, " R3"}, "dataPop cycle", dpAt, expD);
      chk({tag, " R3"}, "rdPush count", rpN, 0);
      if (expD > last) last = expD;
    end else if (cmd == 3'd3) begin
      expD = acc + dat + LAT + 1;
      chk({tag, " R4"}, "rdPush count", rpN, 1);
      chk({tag, " R4"}, "rdPush cycle", rpAt, expD);
      chk({tag, " R4"}, "dataPop count", dpN, 0);
      if (expD > last) last = expD;
    end else begin
      chk({tag, " R5"}, "data strobes", dpN + rpN, 0);
    end
    chk({tag, " R9"}, "ready return cycle", readyAt, last + 1);
  endtask

  task automatic testReset();
    chk("R6", "reset phase", syncPhase, 0);
    chk("R8", "reset errSticky", errSticky, 0);
    chk("R2", "reset strobes", acPop + dataPop + rdPush, 0);
  endtask

  task automatic testPhase();
    syncPulse(3); #1;
    chk("R6", "phase after 3 pulses", syncPhase, 3);
    syncPulse(2); #1;
    chk("R6", "phase wrap", syncPhase, 1);
  endtask

  task automatic testMismatch();
    int ready = 0;
    clearMon();
    @(negedge clk); qWord = mk(3'd3, 6'd1, 6'd2, 2'd2, 2'b00); qValid = 1;
    for (int i = 0; i < 6; i++) begin #1; ready += qReady; @(negedge clk); end
    qValid = 0;
    chk("R7", "ready while tag mismatched", ready, 0);
    chk("R7", "strobes while held", acN + dpN + rpN, 0);
    syncPulse(1); #1;
    chk("R6", "phase after one pulse", syncPhase, 2);
    runCmd("mismatch-then-match R7", 3'd3, 1, 2, 2'd2, '0);
  endtask

  task automatic dropBad(input string tag, input logic [31:0] w);
    int waited = 0;
    clearMon();
    @(negedge clk); qWord = w; qValid = 1;
    #1;
    while (!qReady && waited < 5) begin @(negedge clk); #1; waited++; end
    chk({tag, " R8"}, "cycles before drop", waited, 0);
    @(negedge clk); qValid = 0; qWord = '0;
    #1;
    chk({tag, " R8"}, "errSticky next cycle", errSticky, 1);
    repeat (80) @(negedge clk);
    chk({tag, " R8"}, "strobes from dropped word", acN + dpN + rpN, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; testReset();
    rstN = 1;
    runCmd("write", 3'd1, 3, 5, 2'd0, '0);
    runCmd("read", 3'd3, 0, 2, 2'd0, '0);
    runCmd("nondata", 3'd4, 7, 0, 2'd0, '0);
    runCmd("write equal delays", 3'd1, 4, 4, 2'd0, '0);
    runCmd("read ctl later", 3'd3, 20, 1, 2'd0, '0);
    runCmd("junk fields R10 R1", 3'd1, 2, 9, 2'd0, 32'hFC00_FE00);
    testPhase();
    testMismatch();
    dropBad("reserved set", mk(3'd1, 6'd1, 6'd1, 2'd0, 2'b01));
    dropBad("bad code", mk(3'd2, 6'd1, 6'd1, 2'd2, 2'b00));
    runCmd("after error", 3'd1, 1, 1, 2'd2, '0);
    #1; chk("R8", "errSticky held", errSticky, 1);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule